// File: doc/BRIEF.md
# Completion Ring Writer with Generation Marking

This block is the device-side producer of a host-memory completion ring. Each completion event it takes in carries a 16-bit identifier (the tag of a finished transmit packet, or the id of a filled receive buffer), a length and a kind bit. The block turns each event into a two-word little-endian descriptor and writes it into the next ring slot through a simple word-write port.

No producer index is exposed to the host. Instead, the second word of every descriptor carries a generation bit. The host clears all slots to the current generation before use, and the device always writes the opposite value, so a slot whose bit differs from the host's expected generation is new. The block tracks the write slot and the current generation, and it inverts the generation each time the slot index wraps from the last slot back to slot 0. The generation word is always written in the cycle after the payload word, so a slot never looks valid while half-written.

The host limits how many entries can be outstanding. The block models this with a credit counter that starts at the ring depth, drops by one per descriptor and rises by one on each returned credit. An event that arrives with no credit left is discarded and sets a sticky overrun flag.

Top module: `gcq_writer`

## Requirements
- R1: After reset, mem_we is 0, evt_ready is 1, overrun is 0, gen_o is 0 and credit_cnt equals DEPTH.
- R2: An event is accepted on a rising edge where evt_valid and evt_ready are both 1 and credit_cnt is nonzero. In the cycle after acceptance, evt_ready is 0 and mem_we writes word address 2*slot. In the following cycle, mem_we writes word address 2*slot+1. After that, evt_ready returns to 1.
- R3: The first word holds the tag in bits 15:0, the length in bits 29:16 and zero in bits 31:30. Byte lane n is bits 8n+7:8n, and the lowest-addressed byte is the least significant (little-endian).
- R4: The second word holds the kind in bit 0 (0 = transmit, 1 = receive) and zero in bits 30:1. Bit 31 is the inverse of the current generation at the time of the write, so the first pass over the ring writes 1.
- R5: Slots are filled in increasing order from 0. After slot DEPTH-1, the next slot is 0, and gen_o inverts as the generation word of slot DEPTH-1 is written.
- R6: Each accepted event lowers credit_cnt by one, and each credit_ret pulse raises it by one. When both happen in the same cycle, the count is unchanged. A credit_ret pulse while credit_cnt equals DEPTH is ignored.
- R7: An event offered while credit_cnt is 0 produces no write, leaves the slot and generation unchanged, and sets overrun.
- R8: Once set, overrun stays 1 until reset.
- R9: The generation word of a slot is written only in the cycle directly after that slot's first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Block can take an event this cycle |
| evt_kind | input | 1 | 0 transmit completion, 1 receive completion |
| evt_tag | input | 16 | Completion tag or buffer id |
| evt_len | input | LEN_W | Byte count of the completion |
| credit_ret | input | 1 | Host has freed one ring entry |
| mem_we | output | 1 | Ring word write strobe |
| mem_addr | output | log2(DEPTH)+1 | Ring word address |
| mem_wdata | output | 32 | Ring word data, little-endian byte lanes |
| gen_o | output | 1 | Current generation |
| credit_cnt | output | log2(DEPTH+1) | Free ring entries |
| overrun | output | 1 | Sticky: an event was dropped for lack of credit |

## Verification
A wrong slot index shows at once as a wrong mem_addr on the very next descriptor. A wrong generation does not show on mem_addr. It shows only in bit 31 of a second word, and it may stay hidden until a full lap of DEPTH descriptors has been written, so the stimulus drives many wraps and compares every generation bit. A credit counter that drifts shows on credit_cnt straight away. Its more serious effect, a missed or false drop, only appears when the count reaches zero, so the stimulus drains the ring both with and without credit returns in the same cycle.

// File: rtl/gcq_writer.sv
module gcq_writer #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 14,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int CRED_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_kind,
  input  logic [15:0]       evt_tag,
  input  logic [LEN_W-1:0]  evt_len,
  input  logic              credit_ret,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              gen_o,
  output logic [CRED_W-1:0] credit_cnt,
  output logic              overrun
);
  localparam int PAD_W = 32 - 16 - LEN_W;

  logic             busy;
  logic             kind_q;
  logic [IDX_W-1:0] slot;

  wire take   = evt_valid && !busy;
  wire have   = credit_cnt != '0;
  wire accept = take && have;
  wire drop   = take && !have;
  wire full   = credit_cnt == CRED_W'(DEPTH);
  wire last   = slot == IDX_W'(DEPTH - 1);

  assign evt_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      kind_q     <= 1'b0;
      slot       <= '0;
      gen_o      <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      overrun    <= 1'b0;
      credit_cnt <= CRED_W'(DEPTH);
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        kind_q    <= evt_kind;
        mem_we    <= 1'b1;
        mem_addr  <= {slot, 1'b0};
        mem_wdata <= {{PAD_W{1'b0}}, evt_len, evt_tag};
      end else if (busy) begin
        busy      <= 1'b0;
        mem_we    <= 1'b1;
        mem_addr  <= {slot, 1'b1};
        mem_wdata <= {~gen_o, 30'b0, kind_q};
        slot      <= slot + 1'b1;
        if (last) gen_o <= ~gen_o;
      end else begin
        mem_we <= 1'b0;
      end

      if (drop) overrun <= 1'b1;

      if (accept && !credit_ret)
        credit_cnt <= credit_cnt - 1'b1;
      else if (credit_ret && !accept && !full)
        credit_cnt <= credit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gcq_writer_chk.sv
module gcq_writer_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 14,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int CRED_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              credit_ret,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              gen_o,
  input logic [CRED_W-1:0] credit_cnt,
  input logic              overrun
);
  wire w0 = mem_we && !mem_addr[0];
  wire w1 = mem_we &&  mem_addr[0];

  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w0 |=> w1 && mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1]));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w0 |-> !evt_ready);

  assert_gen_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w1 |-> $past(w0));

  assert_gen_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w1 |-> mem_wdata[31] == !$past(gen_o) && mem_wdata[30:1] == '0);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w1 && mem_addr[ADDR_W-1:1] == IDX_W'(DEPTH - 1) |-> gen_o != $past(gen_o));

  assert_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready && credit_cnt != '0 && !credit_ret
      |=> credit_cnt == $past(credit_cnt) - 1'b1);

  assert_credit_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    credit_cnt <= CRED_W'(DEPTH));

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !mem_we && $stable(gen_o));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind gcq_writer gcq_writer_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .credit_ret(credit_ret), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .gen_o(gen_o), .credit_cnt(credit_cnt),
  .overrun(overrun)
);

// File: tb/test_gcq_writer.sv
`timescale 1ns/1ps
module test_gcq_writer;
  localparam int DEPTH = 16;
  localparam int LEN_W = 14;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 1;
  localparam int CRED_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_kind = 0, credit_ret = 0;
  logic [15:0] evt_tag = '0;
  logic [LEN_W-1:0] evt_len = '0;
  logic evt_ready, mem_we, gen_o, overrun;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [CRED_W-1:0] credit_cnt;

  gcq_writer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_gcq_writer (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_slot = 0, m_cred = DEPTH;
  bit m_gen = 0, m_ovr = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] word0(logic [15:0] t, logic [LEN_W-1:0] l);
    return {2'b00, l, t};
  endfunction

  function automatic logic [31:0] word1(bit k, bit g);
    return {~g, 30'b0, k};
  endfunction

  task automatic give_credit();
    @(negedge clk) credit_ret = 1;
    @(negedge clk) credit_ret = 0;
    if (m_cred < DEPTH) m_cred++;
    chk("R6 credit return", 32'(credit_cnt), 32'(m_cred));
  endtask

  task automatic send(bit k, logic [15:0] t, logic [LEN_W-1:0] l, bit ret);
    @(negedge clk);
    chk("R2 ready idle", 32'(evt_ready), 32'd1);
    evt_valid = 1; evt_kind = k; evt_tag = t; evt_len = l; credit_ret = ret;
    @(negedge clk);
    evt_valid = 0; credit_ret = 0;
    if (m_cred == 0) begin
      m_ovr = 1;
      if (ret) m_cred++;
      chk("R7 no write", 32'(mem_we), 32'd0);
      chk("R7 overrun set", 32'(overrun), 32'd1);
      chk("R7 gen kept", 32'(gen_o), 32'(m_gen));
      chk("R6 credit on drop", 32'(credit_cnt), 32'(m_cred));
    end else begin
      if (!ret) m_cred--;
      chk("R2 first we", 32'(mem_we), 32'd1);
      chk("R2 first addr", 32'(mem_addr), 32'(m_slot * 2));
      chk("R3 first word", mem_wdata, word0(t, l));
      chk("R2 busy", 32'(evt_ready), 32'd0);
      chk("R6 credit", 32'(credit_cnt), 32'(m_cred));
      @(negedge clk);
      chk("R9 second we", 32'(mem_we), 32'd1);
      chk("R5 second addr", 32'(mem_addr), 32'(m_slot * 2 + 1));
      chk("R4 second word", mem_wdata, word1(k, m_gen));
      if (m_slot == DEPTH - 1) begin m_slot = 0; m_gen = ~m_gen; end
      else m_slot++;
      chk("R5 gen_o", 32'(gen_o), 32'(m_gen));
    end
    chk("R8 overrun", 32'(overrun), 32'(m_ovr));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 we", 32'(mem_we), 32'd0);
    chk("R1 ready", 32'(evt_ready), 32'd1);
    chk("R1 overrun", 32'(overrun), 32'd0);
    chk("R1 gen", 32'(gen_o), 32'd0);
    chk("R1 credit", 32'(credit_cnt), 32'(DEPTH));

    give_credit();
    send(0, 16'hBEEF, 14'h3FFF, 0);
    send(1, 16'h0001, 14'h0000, 0);
    send(0, 16'hFFFF, 14'h1234, 1);
    give_credit();
    give_credit();
    for (int i = 0; i < DEPTH; i++)
      send(i[0], 16'(i * 16'h1111), 14'(i * 3), 0);
    send(1, 16'hA5A5, 14'h0AA, 0);
    send(0, 16'h5A5A, 14'h055, 1);
    repeat (4) give_credit();
    send(1, 16'h1357, 14'h2468, 0);
    send(0, 16'h0246, 14'h1357, 1);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) give_credit();
      else send(1'($urandom), 16'($urandom), 14'($urandom), 1'($urandom % 4 == 0));
    end
    send(0, 16'h7777, 14'h1, 0);
    summary();
  end
endmodule